// File: doc/BRIEF.md
# Pre-Adder Operand Stage

This block is the registered operand front end of a multiply-accumulate slice. A wide A operand runs through a register chain of one or two stages. Either of its two taps can be picked. A D operand goes through a single register. A pre-adder then combines the chosen A value with D, and its 25-bit result is the first multiplier operand. A B operand runs through its own chain of one or two stages, and one of its two taps becomes the second multiplier operand. The multiplier and everything after it live outside this block.

A five-bit control word, registered once so that it lines up with the operand registers, drives the datapath. Bit 0 picks the A tap: 1 takes the first stage, 0 takes the second. Bit 1 set to 1 replaces the A operand of the pre-adder with zero. Bit 2 must be 1 for D to reach the pre-adder, and 0 replaces D with zero. Bit 3 set to 1 makes the pre-adder compute D minus A, and 0 makes it compute D plus A. Bit 4 picks the B tap: 1 takes the first stage, 0 takes the second. The pre-adder does not saturate. Callers must keep their operands in range, because the result wraps.

Every register has its own clock enable, and each operand group has a synchronous active-high reset. These enables are the only flow control the block has. It offers no valid/ready handshake and applies no back-pressure. A stage captures its input on any edge where its enable is high, and it holds its value otherwise. The surrounding pipeline sequences those enables.

Top module: `preadd_opnd_stage`

## Requirements
- R1: When mode bit 0 is 1, the pre-adder takes the first A register stage. When it is 0, the pre-adder takes the second A register stage.
- R2: When mode bit 1 is 1, the A operand of the pre-adder is zero.
- R3: When mode bit 2 is 0, the D operand of the pre-adder is zero. D passes only when the bit is 1.
- R4: When mode bit 3 is 1, mult_a equals D minus A. When it is 0, mult_a equals D plus A, after the gating of R2 and R3.
- R5: When mode bit 4 is 1, mult_b is the first B register stage. When it is 0, mult_b is the second B register stage.
- R6: The pre-adder uses only bits 24:0 of the chosen A tap, and bits 29:25 have no effect. The sum or difference wraps modulo 2^25 with no saturation.
- R7: With USE_D = 0, mult_a equals bits 24:0 of the chosen A tap, and mode bits 1 to 3 and the D input have no effect.
- R8: With a register depth of 1, both taps of that operand return the single stage, so mode bit 0 (or mode bit 4) does not change the output.
- R9: A register whose clock enable is low and whose reset is low keeps its value, so mult_a and mult_b stay unchanged across such an edge.
- R10: A reset that is high at a clock edge clears that group's registers to zero, whatever the clock enable is. Resetting B alone leaves mult_a untouched.
- R11: A change of mode_in takes effect only after a clock edge with ce_mode high. mult_a and mult_b respond in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_a | input | 1 | Synchronous reset of the A register chain |
| ce_a1 | input | 1 | Enable of the first A stage |
| ce_a2 | input | 1 | Enable of the second A stage |
| a_in | input | A_W (30) | A operand input |
| rst_b | input | 1 | Synchronous reset of the B register chain |
| ce_b1 | input | 1 | Enable of the first B stage |
| ce_b2 | input | 1 | Enable of the second B stage |
| b_in | input | B_W (18) | B operand input |
| rst_d | input | 1 | Synchronous reset of the D register |
| ce_d | input | 1 | Enable of the D register |
| d_in | input | D_W (25) | D operand input |
| rst_mode | input | 1 | Synchronous reset of the mode register |
| ce_mode | input | 1 | Enable of the mode register |
| mode_in | input | 5 | Control word: bit 4 B tap, bit 3 subtract, bit 2 D pass, bit 1 A zero, bit 0 A tap |
| mult_a | output | D_W (25) | Pre-adder result, the first multiplier operand |
| mult_b | output | B_W (18) | Chosen B tap, the second multiplier operand |

## Verification
The bench goes after wrap-around at both ends of the 25-bit range. A design that saturated, or that carried a 26th bit, would produce a clamped or sign-flipped value there. It loads different values into the two stages of each chain, so a swapped tap decode shows up at once as the wrong operand. It also sets bits 29:25 of A to show that they are ignored. Directed tests hold every enable low, change the mode with only ce_mode high, and reset B on its own. A design that leaked an enable, applied mode_in without registering it, or shared resets across groups would change an output at the wrong time. A second instance with single-stage chains and no D path confirms that the tap choice and the D controls have no effect there.

// File: rtl/preadd_pkg.sv
package preadd_pkg;

  localparam int MODE_W = 5;

  // Bit order matters: the control word is cast onto this struct, bit 4 first.
  typedef struct packed {
    logic b_take_first;  // bit 4
    logic subtract;      // bit 3
    logic d_pass;        // bit 2
    logic a_force_zero;  // bit 1
    logic a_take_first;  // bit 0
  } mode_t;

endpackage

// File: rtl/preadd_pipe_reg.sv
module preadd_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end

endmodule

// File: rtl/preadd_opnd_chain.sv
module preadd_opnd_chain #(
  parameter int W     = 18,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce1,
  input  logic         ce2,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap1,
  output logic [W-1:0] tap2
);

  preadd_pipe_reg #(.W(W)) i_stage1 (
    .clk (clk),
    .rst (rst),
    .ce  (ce1),
    .d   (din),
    .q   (tap1)
  );

  generate
    if (DEPTH == 2) begin : g_two
      preadd_pipe_reg #(.W(W)) i_stage2 (
        .clk (clk),
        .rst (rst),
        .ce  (ce2),
        .d   (tap1),
        .q   (tap2)
      );
    end else begin : g_one
      logic unused_ce2;
      assign unused_ce2 = ce2;
      assign tap2       = tap1;
    end
  endgenerate

endmodule

// File: rtl/preadd_adder.sv
module preadd_adder
  import preadd_pkg::*;
#(
  parameter int PA_W  = 25,
  parameter bit USE_D = 1'b1
) (
  input  mode_t           mode,
  input  logic [PA_W-1:0] a_op,
  input  logic [PA_W-1:0] d_op,
  output logic [PA_W-1:0] sum
);

  generate
    if (USE_D) begin : g_preadd
      logic [PA_W:0] a_x;
      logic [PA_W:0] d_x;
      logic [PA_W:0] r;
      logic          unused_bits;

      always_comb begin
        a_x = mode.a_force_zero ? '0 : {a_op[PA_W-1], a_op};
        d_x = mode.d_pass       ? {d_op[PA_W-1], d_op} : '0;
        r   = mode.subtract     ? (d_x - a_x) : (d_x + a_x);
      end

      assign sum         = r[PA_W-1:0];
      assign unused_bits = r[PA_W] ^ mode.b_take_first ^ mode.a_take_first;
    end else begin : g_direct
      logic unused_bits;
      assign sum         = a_op;
      assign unused_bits = ^{d_op, mode};
    end
  endgenerate

endmodule

// File: rtl/preadd_opnd_stage.sv
module preadd_opnd_stage
  import preadd_pkg::*;
#(
  parameter int A_W     = 30,
  parameter int B_W     = 18,
  parameter int D_W     = 25,
  parameter int A_DEPTH = 2,
  parameter int B_DEPTH = 2,
  parameter bit USE_D   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_a,
  input  logic              ce_a1,
  input  logic              ce_a2,
  input  logic [A_W-1:0]    a_in,
  input  logic              rst_b,
  input  logic              ce_b1,
  input  logic              ce_b2,
  input  logic [B_W-1:0]    b_in,
  input  logic              rst_d,
  input  logic              ce_d,
  input  logic [D_W-1:0]    d_in,
  input  logic              rst_mode,
  input  logic              ce_mode,
  input  logic [MODE_W-1:0] mode_in,
  output logic [D_W-1:0]    mult_a,
  output logic [B_W-1:0]    mult_b
);

  localparam int PA_W = D_W;

  logic [A_W-1:0]    a1_q, a2_q;
  logic [B_W-1:0]    b1_q, b2_q;
  logic [D_W-1:0]    d_q;
  logic [MODE_W-1:0] mode_bits;
  mode_t             mode_q;
  logic [PA_W-1:0]   a_pick;
  logic              unused_a_hi;

  preadd_opnd_chain #(.W(A_W), .DEPTH(A_DEPTH)) i_a_chain (
    .clk  (clk),
    .rst  (rst_a),
    .ce1  (ce_a1),
    .ce2  (ce_a2),
    .din  (a_in),
    .tap1 (a1_q),
    .tap2 (a2_q)
  );

  preadd_opnd_chain #(.W(B_W), .DEPTH(B_DEPTH)) i_b_chain (
    .clk  (clk),
    .rst  (rst_b),
    .ce1  (ce_b1),
    .ce2  (ce_b2),
    .din  (b_in),
    .tap1 (b1_q),
    .tap2 (b2_q)
  );

  preadd_pipe_reg #(.W(D_W)) i_d_reg (
    .clk (clk),
    .rst (rst_d),
    .ce  (ce_d),
    .d   (d_in),
    .q   (d_q)
  );

  preadd_pipe_reg #(.W(MODE_W)) i_mode_reg (
    .clk (clk),
    .rst (rst_mode),
    .ce  (ce_mode),
    .d   (mode_in),
    .q   (mode_bits)
  );

  assign mode_q = mode_t'(mode_bits);

  // Only the low PA_W bits of A enter the pre-adder.
  assign a_pick      = mode_q.a_take_first ? a1_q[PA_W-1:0] : a2_q[PA_W-1:0];
  assign unused_a_hi = ^{a1_q[A_W-1:PA_W], a2_q[A_W-1:PA_W]};

  preadd_adder #(.PA_W(PA_W), .USE_D(USE_D)) i_adder (
    .mode (mode_q),
    .a_op (a_pick),
    .d_op (d_q),
    .sum  (mult_a)
  );

  assign mult_b = mode_q.b_take_first ? b1_q : b2_q;

endmodule

// File: rtl/preadd_opnd_chk.sv
module preadd_opnd_chk #(
  parameter int B_W   = 18,
  parameter int D_W   = 25,
  parameter bit USE_D = 1'b1
) (
  input logic           clk,
  input logic           rst_a,
  input logic           ce_a1,
  input logic           ce_a2,
  input logic           rst_b,
  input logic           ce_b1,
  input logic           ce_b2,
  input logic [B_W-1:0] b_in,
  input logic           rst_d,
  input logic           ce_d,
  input logic           rst_mode,
  input logic           ce_mode,
  input logic [4:0]     mode_in,
  input logic [4:0]     mode_bits,
  input logic [D_W-1:0] mult_a,
  input logic [B_W-1:0] mult_b
);

  // R5: a B value captured into the first stage with bit 4 set appears next cycle
  p_bsel_first_r5: assert property (@(posedge clk) disable iff (rst_mode)
    (ce_b1 && !rst_b && ce_mode && mode_in[4]) |=> (mult_b == $past(b_in)));

  // R9: with every A, D and mode register idle, mult_a holds
  p_hold_a_r9: assert property (@(posedge clk) disable iff (rst_mode)
    (!ce_a1 && !ce_a2 && !ce_d && !ce_mode && !rst_a && !rst_d) |=> $stable(mult_a));

  // R9: with the B chain and mode idle, mult_b holds
  p_hold_b_r9: assert property (@(posedge clk) disable iff (rst_mode)
    (!ce_b1 && !ce_b2 && !ce_mode && !rst_b) |=> $stable(mult_b));

  // R10: resetting the B chain zeroes mult_b
  p_reset_b_r10: assert property (@(posedge clk) disable iff (rst_mode)
    rst_b |=> (mult_b == '0));

  // R10: resetting A and D zeroes the pre-adder result
  p_reset_a_r10: assert property (@(posedge clk) disable iff (rst_mode)
    (rst_a && rst_d) |=> (mult_a == '0));

  generate
    if (USE_D) begin : g_gate
      // R2 and R3: both pre-adder inputs gated to zero give zero
      p_both_gated_r3: assert property (@(posedge clk) disable iff (rst_mode)
        (mode_bits[1] && !mode_bits[2]) |-> (mult_a == '0));
    end
  endgenerate

endmodule

bind preadd_opnd_stage preadd_opnd_chk #(
  .B_W   (B_W),
  .D_W   (D_W),
  .USE_D (USE_D)
) i_preadd_opnd_chk (
  .clk       (clk),
  .rst_a     (rst_a),
  .ce_a1     (ce_a1),
  .ce_a2     (ce_a2),
  .rst_b     (rst_b),
  .ce_b1     (ce_b1),
  .ce_b2     (ce_b2),
  .b_in      (b_in),
  .rst_d     (rst_d),
  .ce_d      (ce_d),
  .rst_mode  (rst_mode),
  .ce_mode   (ce_mode),
  .mode_in   (mode_in),
  .mode_bits (mode_bits),
  .mult_a    (mult_a),
  .mult_b    (mult_b)
);

// File: tb/test_preadd_opnd_stage.sv
`timescale 1ns/1ps
module test_preadd_opnd_stage;

  logic        clk = 1'b0;
  logic        rst_a = 1'b1, rst_b = 1'b1, rst_d = 1'b1, rst_mode = 1'b1;
  logic        ce_a1 = 1'b0, ce_a2 = 1'b0, ce_b1 = 1'b0, ce_b2 = 1'b0;
  logic        ce_d = 1'b0, ce_mode = 1'b0;
  logic [29:0] a_in = '0;
  logic [17:0] b_in = '0;
  logic [24:0] d_in = '0;
  logic [4:0]  mode_in = '0;
  logic [24:0] mult_a, lt_mult_a;
  logic [17:0] mult_b, lt_mult_b;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  preadd_opnd_stage i_preadd_opnd_stage (
    .clk(clk), .rst_a(rst_a), .ce_a1(ce_a1), .ce_a2(ce_a2), .a_in(a_in),
    .rst_b(rst_b), .ce_b1(ce_b1), .ce_b2(ce_b2), .b_in(b_in),
    .rst_d(rst_d), .ce_d(ce_d), .d_in(d_in),
    .rst_mode(rst_mode), .ce_mode(ce_mode), .mode_in(mode_in),
    .mult_a(mult_a), .mult_b(mult_b)
  );

  // Single-stage chains, no D path
  preadd_opnd_stage #(.A_DEPTH(1), .B_DEPTH(1), .USE_D(1'b0)) i_preadd_opnd_stage_lite (
    .clk(clk), .rst_a(rst_a), .ce_a1(ce_a1), .ce_a2(ce_a2), .a_in(a_in),
    .rst_b(rst_b), .ce_b1(ce_b1), .ce_b2(ce_b2), .b_in(b_in),
    .rst_d(rst_d), .ce_d(ce_d), .d_in(d_in),
    .rst_mode(rst_mode), .ce_mode(ce_mode), .mode_in(mode_in),
    .mult_a(lt_mult_a), .mult_b(lt_mult_b)
  );

  // {mode[4:0], a_first_load[29:0], a_second_load[29:0], d[24:0], b_first_load[17:0], b_second_load[17:0]}
  localparam int NV = 11;
  localparam logic [125:0] VECS [NV] = '{
    {5'b00100, 30'h0000_0010, 30'h0000_0020, 25'h000_0100, 18'h00003, 18'h00005},
    {5'b00101, 30'h0000_0011, 30'h0000_0022, 25'h000_0100, 18'h00007, 18'h0000B},
    {5'b01101, 30'h0000_0013, 30'h0000_0020, 25'h000_0100, 18'h00011, 18'h00013},
    {5'b00110, 30'h0000_0044, 30'h0000_0055, 25'h000_0100, 18'h00017, 18'h0001D},
    {5'b00001, 30'h0000_0066, 30'h0000_0020, 25'h000_0777, 18'h0001F, 18'h00025},
    {5'b01001, 30'h0000_0001, 30'h0000_0020, 25'h000_0777, 18'h00029, 18'h0002B},
    {5'b10100, 30'h0000_0009, 30'h0000_000A, 25'h000_0100, 18'h3FFFF, 18'h2AAAA},
    {5'b00101, 30'h0000_0007, 30'h0000_0001, 25'h0FF_FFFF, 18'h00101, 18'h00202},
    {5'b01101, 30'h0000_0007, 30'h0000_0001, 25'h100_0000, 18'h00303, 18'h00404},
    {5'b00101, 30'h0000_0003, 30'h3E00_0005, 25'h000_0010, 18'h00505, 18'h00606},
    {5'b11110, 30'h0123_4567, 30'h0765_4321, 25'h0AB_CDEF, 18'h01234, 18'h04321}
  };

  // Expected pre-adder result. a_new is the first stage (latest load) and a_old the second stage.
  function automatic logic [24:0] exp_pre(logic [4:0] m, logic [29:0] a_new,
                                          logic [29:0] a_old, logic [24:0] d);
    logic [24:0] a_v;
    logic [24:0] d_v;
    a_v = m[0] ? a_new[24:0] : a_old[24:0];
    if (m[1]) a_v = '0;
    d_v = m[2] ? d : '0;
    return m[3] ? (d_v - a_v) : (d_v + a_v);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ce(logic v);
    ce_a1 = v; ce_a2 = v; ce_b1 = v; ce_b2 = v; ce_d = v; ce_mode = v;
  endtask

  logic [4:0]  lm;
  logic [29:0] lp, lq;
  logic [24:0] ld;
  logic [17:0] lbp, lbq;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_ce(1'b1);
    a_in = 30'h3FFF_FFFF; b_in = 18'h3FFFF; d_in = 25'h1FF_FFFF; mode_in = 5'b11111;
    repeat (3) @(negedge clk);
    // R10: reset wins over enables
    check("R10 reset mult_a", 32'(mult_a), 32'h0);
    check("R10 reset mult_b", 32'(mult_b), 32'h0);
    check("R10 reset lite mult_a", 32'(lt_mult_a), 32'h0);
    rst_a = 1'b0; rst_b = 1'b0; rst_d = 1'b0; rst_mode = 1'b0;

    for (int i = 0; i < NV; i++) begin
      lm = VECS[i][125:121]; lp = VECS[i][120:91]; lq = VECS[i][90:61];
      ld = VECS[i][60:36];   lbp = VECS[i][35:18]; lbq = VECS[i][17:0];
      set_ce(1'b1);
      a_in = lp; b_in = lbp;
      @(negedge clk);
      a_in = lq; b_in = lbq; d_in = ld; mode_in = lm;
      @(negedge clk);
      // R1 R2 R3 R4 R6: first stage holds lq, second stage holds lp
      check($sformatf("R1/R2/R3/R4/R6 vec %0d mult_a", i), 32'(mult_a),
            32'(exp_pre(lm, lq, lp, ld)));
      check($sformatf("R5 vec %0d mult_b", i), 32'(mult_b), 32'(lm[4] ? lbq : lbp));
      check($sformatf("R7/R8 vec %0d lite mult_a", i), 32'(lt_mult_a), 32'(lq[24:0]));
      check($sformatf("R8 vec %0d lite mult_b", i), 32'(lt_mult_b), 32'(lbq));
    end

    // R9: all enables low, inputs change, outputs hold
    set_ce(1'b0);
    a_in = 30'h1555_5555; b_in = 18'h15555; d_in = 25'h155_5555; mode_in = 5'b00000;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold mult_a", 32'(mult_a), 32'(exp_pre(lm, lq, lp, ld)));
    check("R9 hold mult_b", 32'(mult_b), 32'(lm[4] ? lbq : lbp));
    check("R9 hold lite mult_a", 32'(lt_mult_a), 32'(lq[24:0]));

    // R11: only the mode register loads; new mode applies after that edge
    mode_in = 5'b01100;
    check("R11 before mode edge mult_a", 32'(mult_a), 32'(exp_pre(lm, lq, lp, ld)));
    ce_mode = 1'b1;
    @(negedge clk);
    ce_mode = 1'b0;
    check("R11 after mode edge mult_a", 32'(mult_a), 32'(exp_pre(5'b01100, lq, lp, ld)));
    check("R11 after mode edge mult_b", 32'(mult_b), 32'(lbp));
    check("R7 lite ignores mode bits", 32'(lt_mult_a), 32'(lq[24:0]));

    // R10: B reset alone leaves mult_a untouched
    rst_b = 1'b1;
    @(negedge clk);
    rst_b = 1'b0;
    check("R10 b reset mult_b", 32'(mult_b), 32'h0);
    check("R10 b reset keeps mult_a", 32'(mult_a), 32'(exp_pre(5'b01100, lq, lp, ld)));

    // R6: wrap at the negative end: 0 - 1 with both A stages loaded with 1
    set_ce(1'b1);
    a_in = 30'h0000_0001; d_in = 25'h0; mode_in = 5'b01100;
    @(negedge clk);
    @(negedge clk);
    check("R6 wrap below zero", 32'(mult_a), 32'h01FF_FFFF);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule